// File: doc/BRIEF.md
# Bus Error Capture and Interrupt Registers

This block sits beside a bus bridge and keeps a record of the first bridged transaction whose downstream response was an error. When the bridge reports an errored read or write, the block sets a sticky status bit for that direction. If no status bit was already set, it also stores the target address and a word of qualifiers: the response code, the direction, the transfer size, the transfer type and the requesting master's ID. Later errors set status bits but leave the stored record alone until software has cleared every status bit.

An interrupt line is driven from the status bits. It passes through a per-source enable register and then a single global enable. The line rises when an enabled error arrives, so it can be used as a rising-edge interrupt. Software reaches the registers through a simple request port that has already been decoded from the host bus. Only single-beat, aligned, 32-bit accesses are accepted. Every other access is acknowledged with an error and changes nothing.

Top module: `errcap_regs`

## Requirements
- R1: After reset every register reads 0, and `irq`, `reg_ack` and `reg_err` are 0.
- R2: An access with `reg_size`=2 (word), `reg_burst`=0 and `reg_addr[1:0]`=0 is answered one cycle later with `reg_ack`=1 and `reg_err`=0. A read returns the register at word index `reg_addr[4:2]` on `reg_rdata`. A write returns 0 there. Indices 5 to 7 read 0 and ignore writes.
- R3: An access with a burst, a size other than word, or a misaligned address is answered one cycle later with `reg_ack`=1, `reg_err`=1 and `reg_rdata`=0, and it changes no register.
- R4: Index 0 is the global enable, in bit 0. Index 1 holds the per-source enables: bit 0 for read errors, bit 1 for write errors. All other bits of both registers read 0.
- R5: An error event (`evt_valid`=1) sets status bit 0 (index 2) when `evt_is_read`=1 and status bit 1 otherwise. The bit is set at the same clock edge.
- R6: An error event that arrives while both status bits are 0 loads index 3 with `evt_addr`. It also loads index 4 with: response in [1:0], direction in [4], size in [11:8], type in [14:12], and master ID in [19:16]. All other bits of index 4 are 0.
- R7: While any status bit is 1, further events leave indices 3 and 4 unchanged.
- R8: Writing the status register clears each bit written as 1 and keeps each bit written as 0. An event in the same cycle as a clear sets its bit regardless.
- R9: `irq` equals global enable AND the OR of (status AND per-source enable). It follows register changes in the same cycle they take effect.
- R10: Writes to indices 3 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address within the register space |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| reg_burst | input | 1 | Access is part of a multi-beat transfer |
| reg_wdata | input | 32 | Write data |
| reg_ack | output | 1 | Access answered |
| reg_err | output | 1 | Access rejected |
| reg_rdata | output | 32 | Read data |
| evt_valid | input | 1 | Downstream error response observed |
| evt_is_read | input | 1 | Errored transaction was a read |
| evt_master | input | MID_W | Requesting master ID |
| evt_size | input | 4 | Transfer size qualifier |
| evt_type | input | 3 | Transfer type qualifier |
| evt_resp | input | 2 | Response code returned |
| evt_addr | input | 32 | Target address of the errored transaction |
| irq | output | 1 | Interrupt, rises on an enabled error |

## Verification
The stimulus table moves through several phases. It programs the enables, then sends a read error followed by a write error, which separates first-error capture from later overwrites. It then tries illegal sizes, bursts and writes to the capture registers, checking that none of them alters state. Next it clears the status bits one at a time and lowers the enables, which shows each enable level gating `irq` on its own. Directed cases then cover a misaligned address, an event and a clear in the same cycle, a capture attempted while the status is still set, and a second reset.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    localparam int unsigned SZ_WORD = 2;

    typedef enum logic [2:0] {
        IDX_GIE  = 3'd0,
        IDX_IEN  = 3'd1,
        IDX_STAT = 3'd2,
        IDX_CADR = 3'd3,
        IDX_CQUL = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic       ok;
        logic       bad;
        logic       wr;
        logic [2:0] idx;
    } acc_t;

endpackage

// File: rtl/errcap_decode.sv
module errcap_decode
    import errcap_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              burst,
    output acc_t              acc
);
    localparam int unsigned IDX_LO = 2;

    logic legal;
    logic upper_zero;

    always_comb begin
        legal = (size == 2'(SZ_WORD)) && !burst && (addr[1:0] == 2'b00);
        upper_zero = 1'b1;
        for (int i = IDX_LO + 3; i < int'(ADDR_W); i++) begin
            if (addr[i]) upper_zero = 1'b0;
        end
        acc.ok  = req && legal;
        acc.bad = req && !legal;
        acc.wr  = we;
        acc.idx = upper_zero ? addr[IDX_LO +: 3] : 3'd7;
    end
endmodule

// File: rtl/errcap_capture.sv
module errcap_capture #(
    parameter int unsigned MID_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic             evt_is_read,
    input  logic [MID_W-1:0] evt_master,
    input  logic [3:0]       evt_size,
    input  logic [2:0]       evt_type,
    input  logic [1:0]       evt_resp,
    input  logic [31:0]      evt_addr,
    input  logic             clr_en,
    input  logic [1:0]       clr_mask,
    input  logic             bad_acc,
    output logic [1:0]       stat_q,
    output logic [31:0]      cap_addr_q,
    output logic [31:0]      cap_qual_q
);
    localparam int unsigned MID_LSB = 16;

    typedef struct packed {
        logic [1:0]  stat;
        logic [31:0] addr;
        logic [31:0] qual;
    } cap_t;

    cap_t st_d, st_q;
    logic [1:0]  set_v;
    logic [31:0] qual_v;

    always_comb begin
        set_v = 2'b00;
        if (evt_valid) set_v = evt_is_read ? 2'b01 : 2'b10;
        qual_v = '0;
        qual_v[1:0]   = evt_resp;
        qual_v[4]     = evt_is_read;
        qual_v[11:8]  = evt_size;
        qual_v[14:12] = evt_type;
        qual_v[MID_LSB +: MID_W] = evt_master;

        st_d = st_q;
        st_d.stat = (st_q.stat & ~(clr_en ? clr_mask : 2'b00)) | set_v;
        if (evt_valid && (st_q.stat == 2'b00)) begin
            st_d.addr = evt_addr;
            st_d.qual = qual_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stat_q     = st_q.stat;
    assign cap_addr_q = st_q.addr;
    assign cap_qual_q = st_q.qual;

    AST_RD_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_is_read) |=> stat_q[0]); // R5
    AST_WR_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_is_read) |=> stat_q[1]); // R5
    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && stat_q == 2'b00) |=> (cap_addr_q == $past(evt_addr))); // R6
    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (stat_q != 2'b00) |=> ($stable(cap_addr_q) && $stable(cap_qual_q))); // R7
    AST_BAD_KEEPS_STAT: assert property (@(posedge clk) disable iff (rst)
        (bad_acc && !evt_valid) |=> $stable(stat_q)); // R3
endmodule

// File: rtl/errcap_regs.sv
module errcap_regs
    import errcap_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned MID_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic              reg_burst,
    input  logic [31:0]       reg_wdata,
    output logic              reg_ack,
    output logic              reg_err,
    output logic [31:0]       reg_rdata,
    input  logic              evt_valid,
    input  logic              evt_is_read,
    input  logic [MID_W-1:0]  evt_master,
    input  logic [3:0]        evt_size,
    input  logic [2:0]        evt_type,
    input  logic [1:0]        evt_resp,
    input  logic [31:0]       evt_addr,
    output logic              irq
);
    typedef struct packed {
        logic        gie;
        logic [1:0]  ien;
        logic        ack;
        logic        err;
        logic [31:0] rdata;
    } top_t;

    top_t st_d, st_q;
    acc_t acc;
    logic [1:0]  stat;
    logic [31:0] cap_addr, cap_qual;
    logic        clr_en;

    errcap_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req   (reg_req),
        .we    (reg_we),
        .addr  (reg_addr),
        .size  (reg_size),
        .burst (reg_burst),
        .acc   (acc)
    );

    assign clr_en = acc.ok && acc.wr && (acc.idx == IDX_STAT);

    errcap_capture #(.MID_W(MID_W)) u_capture (
        .clk         (clk),
        .rst         (rst),
        .evt_valid   (evt_valid),
        .evt_is_read (evt_is_read),
        .evt_master  (evt_master),
        .evt_size    (evt_size),
        .evt_type    (evt_type),
        .evt_resp    (evt_resp),
        .evt_addr    (evt_addr),
        .clr_en      (clr_en),
        .clr_mask    (reg_wdata[1:0]),
        .bad_acc     (acc.bad),
        .stat_q      (stat),
        .cap_addr_q  (cap_addr),
        .cap_qual_q  (cap_qual)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ack   = reg_req;
        st_d.err   = acc.bad;
        st_d.rdata = '0;
        if (acc.ok && acc.wr) begin
            if (acc.idx == IDX_GIE) st_d.gie = reg_wdata[0];
            if (acc.idx == IDX_IEN) st_d.ien = reg_wdata[1:0];
        end
        if (acc.ok && !acc.wr) begin
            case (acc.idx)
                IDX_GIE:  st_d.rdata = {31'b0, st_q.gie};
                IDX_IEN:  st_d.rdata = {30'b0, st_q.ien};
                IDX_STAT: st_d.rdata = {30'b0, stat};
                IDX_CADR: st_d.rdata = cap_addr;
                IDX_CQUL: st_d.rdata = cap_qual;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign reg_ack   = st_q.ack;
    assign reg_err   = st_q.err;
    assign reg_rdata = st_q.rdata;
    assign irq       = st_q.gie && |(stat & st_q.ien);

    AST_REQ_ACKED: assert property (@(posedge clk) disable iff (rst)
        reg_req |=> reg_ack); // R2
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        reg_ack |-> $past(reg_req)); // R2
    AST_BAD_ERRS: assert property (@(posedge clk) disable iff (rst)
        (reg_req && acc.bad) |=> (reg_err && reg_rdata == 32'd0)); // R3
    AST_BAD_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
        (reg_req && acc.bad) |=> ($stable(st_q.gie) && $stable(st_q.ien))); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st_q.gie && stat != 2'b00)); // R9
endmodule

// File: tb/errcap_regs_tb.sv
module errcap_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_req = 0, reg_we = 0, reg_burst = 0;
    logic [4:0]  reg_addr = 0;
    logic [1:0]  reg_size = 2;
    logic [31:0] reg_wdata = 0;
    logic        reg_ack, reg_err, irq;
    logic [31:0] reg_rdata;
    logic        evt_valid = 0, evt_is_read = 0;
    logic [3:0]  evt_master = 0, evt_size = 0;
    logic [2:0]  evt_type = 0;
    logic [1:0]  evt_resp = 0;
    logic [31:0] evt_addr = 0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errcap_regs u_dut (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_burst(reg_burst),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err),
        .reg_rdata(reg_rdata), .evt_valid(evt_valid), .evt_is_read(evt_is_read),
        .evt_master(evt_master), .evt_size(evt_size), .evt_type(evt_type),
        .evt_resp(evt_resp), .evt_addr(evt_addr), .irq(irq)
    );

    typedef struct packed {
        logic        ev;      // 1 = error event, 0 = register access
        logic        we;
        logic [2:0]  idx;
        logic [31:0] data;    // write data or event address
        logic [1:0]  size;
        logic        burst;
        logic        ev_rd;
        logic [3:0]  ev_mid;
        logic [3:0]  ev_sz;
        logic [2:0]  ev_ty;
        logic [1:0]  ev_resp;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic        exp_irq;
        int          req;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{0,0,0,32'h0,2,0,0,0,0,0,0,32'h0,0,0,4},                    // R4 read gie
        '{0,1,0,32'h1,2,0,0,0,0,0,0,32'h0,0,0,2},                    // R2 write gie
        '{0,0,0,32'h0,2,0,0,0,0,0,0,32'h1,0,0,4},                    // R4
        '{0,1,1,32'hFFFFFFFF,2,0,0,0,0,0,0,32'h0,0,0,2},
        '{0,0,1,32'h0,2,0,0,0,0,0,0,32'h3,0,0,4},                    // R4 masked
        '{1,0,0,32'h10000040,2,0,1,5,2,0,2,32'h0,0,1,5},             // R5 read err
        '{1,0,0,32'h20000080,2,0,0,3,0,6,3,32'h0,0,1,5},             // R5 write err
        '{0,0,2,32'h0,2,0,0,0,0,0,0,32'h3,0,1,5},
        '{0,0,3,32'h0,2,0,0,0,0,0,0,32'h10000040,0,1,7},             // R7
        '{0,0,4,32'h0,2,0,0,0,0,0,0,32'h00050212,0,1,6},             // R6
        '{0,1,2,32'h3,1,0,0,0,0,0,0,32'h0,1,1,3},                    // R3 half
        '{0,0,2,32'h0,2,1,0,0,0,0,0,32'h0,1,1,3},                    // R3 burst
        '{0,0,2,32'h0,2,0,0,0,0,0,0,32'h3,0,1,3},                    // R3 unchanged
        '{0,1,3,32'hDEAD,2,0,0,0,0,0,0,32'h0,0,1,10},                // R10
        '{0,0,3,32'h0,2,0,0,0,0,0,0,32'h10000040,0,1,10},
        '{0,1,2,32'h1,2,0,0,0,0,0,0,32'h0,0,1,8},                    // R8 clear rd
        '{0,0,2,32'h0,2,0,0,0,0,0,0,32'h2,0,1,8},
        '{0,1,1,32'h1,2,0,0,0,0,0,0,32'h0,0,0,9},                    // R9 ien gates
        '{0,1,2,32'h2,2,0,0,0,0,0,0,32'h0,0,0,8},
        '{1,0,0,32'h30000004,2,0,1,1,3,1,2,32'h0,0,1,9},
        '{0,0,3,32'h0,2,0,0,0,0,0,0,32'h30000004,0,1,6},             // R6 recapture
        '{0,1,0,32'h0,2,0,0,0,0,0,0,32'h0,0,0,9},                    // R9 gie gates
        '{0,0,7,32'h0,2,0,0,0,0,0,0,32'h0,0,0,2}                     // R2 unmapped
    };

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        reg_req = 0; reg_we = 0; reg_burst = 0; reg_size = 2; reg_addr = 0;
        reg_wdata = 0; evt_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(irq == 0 && reg_ack == 0 && reg_err == 0, "R1", "reset outputs",
              {29'b0, irq, reg_ack, reg_err}, 32'h0);
        rst = 0;
        for (int i = 0; i < NV; i++) begin
            idle();
            if (VEC[i].ev) begin
                evt_valid = 1; evt_is_read = VEC[i].ev_rd; evt_addr = VEC[i].data;
                evt_master = VEC[i].ev_mid; evt_size = VEC[i].ev_sz;
                evt_type = VEC[i].ev_ty; evt_resp = VEC[i].ev_resp;
            end else begin
                reg_req = 1; reg_we = VEC[i].we; reg_addr = {VEC[i].idx, 2'b00};
                reg_wdata = VEC[i].data; reg_size = VEC[i].size;
                reg_burst = VEC[i].burst;
            end
            @(negedge clk);
            if (!VEC[i].ev) begin
                check(reg_ack == 1 && reg_err == VEC[i].exp_err,
                      $sformatf("R%0d", VEC[i].req), $sformatf("ack/err step %0d", i),
                      {30'b0, reg_ack, reg_err}, {30'b0, 1'b1, VEC[i].exp_err});
                check(reg_rdata == VEC[i].exp_rd, $sformatf("R%0d", VEC[i].req),
                      $sformatf("rdata step %0d", i), reg_rdata, VEC[i].exp_rd);
            end
            check(irq == VEC[i].exp_irq, $sformatf("R%0d", VEC[i].req),
                  $sformatf("irq step %0d", i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
        end

        // R3: misaligned word access
        idle(); reg_req = 1; reg_addr = 5'd9;
        @(negedge clk);
        check(reg_err == 1 && reg_rdata == 0, "R3", "misaligned", {31'b0, reg_err}, 32'h1);

        // R8: clear and event in one cycle, set wins (status is 1 here)
        idle(); reg_req = 1; reg_we = 1; reg_addr = 5'd8; reg_wdata = 32'h1;
        evt_valid = 1; evt_is_read = 1; evt_addr = 32'h44440000;
        @(negedge clk);
        idle(); reg_req = 1; reg_addr = 5'd8;
        @(negedge clk);
        check(reg_rdata == 32'h1, "R8", "set beats clear", reg_rdata, 32'h1);

        // R7: capture untouched by that event
        idle(); reg_req = 1; reg_addr = 5'd12;
        @(negedge clk);
        check(reg_rdata == 32'h30000004, "R7", "frozen capture", reg_rdata, 32'h30000004);

        // R1: second reset clears registers
        idle(); rst = 1;
        @(negedge clk);
        rst = 0; reg_req = 1; reg_addr = 5'd8;
        @(negedge clk);
        check(reg_rdata == 0 && irq == 0, "R1", "status after reset", reg_rdata, 32'h0);
        idle(); reg_req = 1; reg_addr = 5'd4;
        @(negedge clk);
        check(reg_rdata == 0, "R1", "ien after reset", reg_rdata, 32'h0);
        idle();
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule